// File: doc/BRIEF.md
# Half-Duplex Collision Detector

This block sits in one channel of an Ethernet physical-layer device and decides when the channel is in collision. It takes activity flags from the transmit and receive paths and the channel configuration (duplex, link state, loopback, line rate). From these it drives the collision and carrier-sense signals for the MAC-facing side. It also drives a flag that forces receive data to zero, a flag that enables the twisted-pair drivers and a flag that permits transmit-to-carrier loopback. An active-low indicator output can be configured to show collisions as a stretched pulse that a person can see.

The block also provides a collision-test mode. In that mode the MAC transmit enable is returned on the collision output and the line drivers are switched off, so the MAC's collision handling can be tested without a cable. At 10 Mbps an SQE test or a jabber condition also raises collision. Every output is registered and follows its inputs by one clock. A two-flop synchronizer releases the asynchronous reset cleanly.

Top module: `hdx_collision_unit`

## Requirements
- R1: With full_duplex, link_fail and diag_loop all low and col_test low, tx_active and rx_active both high in one cycle give col high in the next cycle.
- R2: If any of full_duplex, link_fail or diag_loop is high, col_test low, col stays low in the next cycle whatever tx_active, rx_active, sqe_test or jabber do.
- R3: crs in the next cycle is rx_active, OR tx_active in half duplex. Once a collision has begun, crs stays high until tx_active and rx_active are both low.
- R4: crs_loop_en is high in half duplex while no collision is held, and low while a collision is held (from its first cycle until both activity flags drop) or in full duplex.
- R5: With col_test high, col in the next cycle equals tx_en and tp_out_en is low. With col_test low, tp_out_en is high.
- R6: With speed_10 high and the gating of R2 open, sqe_test or jabber raise col in the next cycle. With speed_10 low they have no effect.
- R7: rxd_zero is high in the next cycle exactly when speed_10 is high and a real collision exists (activity overlap, SQE test or jabber, gated as in R2). Collision test alone does not set it.
- R8: With led_mode equal to 2'b10, each rising edge of col drives led_n low for exactly LED_CYCLES clocks, beginning with the same edge. A new rising edge restarts the full period.
- R9: With led_mode not equal to 2'b10, led_n is high in the next cycle.
- R10: While reset is applied, col, crs, rxd_zero and crs_loop_en are low and tp_out_en and led_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmit path is sending a packet |
| rx_active | input | 1 | Receive path sees non-idle symbols or passes squelch |
| full_duplex | input | 1 | Channel runs full duplex |
| link_fail | input | 1 | Link is in the failed state |
| diag_loop | input | 1 | Diagnostic loopback mode |
| col_test | input | 1 | Collision test mode bit |
| tx_en | input | 1 | MAC transmit enable |
| speed_10 | input | 1 | 1 = 10 Mbps, 0 = 100 Mbps |
| sqe_test | input | 1 | SQE test in progress |
| jabber | input | 1 | Jabber condition detected |
| led_mode | input | LED_MODE_W | Indicator function select, 2'b10 = collision |
| col | output | 1 | Collision |
| crs | output | 1 | Carrier sense |
| tp_out_en | output | 1 | Twisted-pair driver enable |
| rxd_zero | output | 1 | Force receive data to zero |
| crs_loop_en | output | 1 | Transmit-to-carrier loopback permitted |
| led_n | output | 1 | Active-low collision indicator |

## Verification
The collision path gets transmit alone, receive alone, overlap, and overlap in which one side drops before the other. The drop order separates the held carrier and the suppressed loopback from plain activity. Each gating input is applied on its own during overlap, so that a missing term in the gate shows up. SQE test and jabber are driven at both line rates, which separates the 10 Mbps extra sources from the shared path. Two collisions spaced closer than the indicator period show whether the stretcher restarts or runs from the first edge.

// File: rtl/hdx_col_pkg.sv
package hdx_col_pkg;

  localparam int LED_MODE_W = 2;
  localparam logic [LED_MODE_W-1:0] LED_SEL_COLLISION = 2'b10;

  typedef struct packed {
    logic full_duplex;
    logic link_fail;
    logic diag_loop;
  } gate_ctrl_t;

  typedef struct packed {
    logic speed_10;
    logic sqe_test;
    logic jabber;
  } ten_src_t;

  function automatic logic gate_open(input gate_ctrl_t g);
    return !(g.full_duplex || g.link_fail || g.diag_loop);
  endfunction

endpackage

// File: rtl/hdx_col_gate.sv
module hdx_col_gate
  import hdx_col_pkg::*;
(
  input  gate_ctrl_t gate,
  input  ten_src_t   ten,
  input  logic       tx_active,
  input  logic       rx_active,
  input  logic       col_test,
  input  logic       tx_en,
  output logic       gate_ok,
  output logic       overlap,
  output logic       col_next,
  output logic       rxd_zero_next
);

  logic extra_src;
  logic real_col;

  always_comb begin
    gate_ok       = gate_open(gate);
    overlap       = gate_ok && tx_active && rx_active;
    extra_src     = gate_ok && ten.speed_10 && (ten.sqe_test || ten.jabber);
    real_col      = overlap || extra_src;
    col_next      = col_test ? tx_en : real_col;
    rxd_zero_next = ten.speed_10 && real_col;
  end

endmodule

// File: rtl/hdx_carrier_hold.sv
module hdx_carrier_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_ok,
  input  logic overlap,
  input  logic full_duplex,
  input  logic tx_active,
  input  logic rx_active,
  output logic crs,
  output logic crs_loop_en
);

  logic held_q, held_d;
  logic crs_q, crs_d;
  logic loop_q, loop_d;
  logic any_act;

  always_comb begin
    any_act = tx_active || rx_active;
    held_d  = gate_ok && (overlap || (held_q && any_act));
    loop_d  = !full_duplex && !held_d;
    crs_d   = rx_active || (tx_active && loop_d) || held_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      crs_q  <= 1'b0;
      loop_q <= 1'b0;
    end else begin
      held_q <= held_d;
      crs_q  <= crs_d;
      loop_q <= loop_d;
    end
  end

  assign crs         = crs_q;
  assign crs_loop_en = loop_q;

endmodule

// File: rtl/hdx_led_stretch.sv
module hdx_led_stretch
  import hdx_col_pkg::*;
#(
  parameter int LED_CYCLES = 10_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trigger,
  input  logic [LED_MODE_W-1:0] led_mode,
  output logic                  led_n
);

  localparam int CNT_W = $clog2(LED_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LED_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             led_n_q, led_n_d;

  always_comb begin
    cnt_en = trigger || (cnt_q != '0);
    if (trigger) cnt_d = CNT_LOAD;
    else         cnt_d = cnt_q - 1'b1;
    led_n_d = !((led_mode == LED_SEL_COLLISION) &&
                (cnt_en ? (cnt_d != '0) : 1'b0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_n_q <= 1'b1;
    else        led_n_q <= led_n_d;
  end

  assign led_n = led_n_q;

endmodule

// File: rtl/hdx_collision_unit.sv
module hdx_collision_unit
  import hdx_col_pkg::*;
#(
  parameter int LED_CYCLES = 10_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_active,
  input  logic                  rx_active,
  input  logic                  full_duplex,
  input  logic                  link_fail,
  input  logic                  diag_loop,
  input  logic                  col_test,
  input  logic                  tx_en,
  input  logic                  speed_10,
  input  logic                  sqe_test,
  input  logic                  jabber,
  input  logic [LED_MODE_W-1:0] led_mode,
  output logic                  col,
  output logic                  crs,
  output logic                  tp_out_en,
  output logic                  rxd_zero,
  output logic                  crs_loop_en,
  output logic                  led_n
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  gate_ctrl_t gate;
  ten_src_t   ten;
  logic gate_ok, overlap, col_next, rxd_zero_next;

  assign gate = '{full_duplex: full_duplex, link_fail: link_fail, diag_loop: diag_loop};
  assign ten  = '{speed_10: speed_10, sqe_test: sqe_test, jabber: jabber};

  hdx_col_gate u_gate (
    .gate          (gate),
    .ten           (ten),
    .tx_active     (tx_active),
    .rx_active     (rx_active),
    .col_test      (col_test),
    .tx_en         (tx_en),
    .gate_ok       (gate_ok),
    .overlap       (overlap),
    .col_next      (col_next),
    .rxd_zero_next (rxd_zero_next)
  );

  hdx_carrier_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .gate_ok     (gate_ok),
    .overlap     (overlap),
    .full_duplex (full_duplex),
    .tx_active   (tx_active),
    .rx_active   (rx_active),
    .crs         (crs),
    .crs_loop_en (crs_loop_en)
  );

  logic col_q, tp_q, rz_q;
  logic col_rise;

  always_comb col_rise = col_next && !col_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      col_q <= 1'b0;
      tp_q  <= 1'b1;
      rz_q  <= 1'b0;
    end else begin
      col_q <= col_next;
      tp_q  <= !col_test;
      rz_q  <= rxd_zero_next;
    end
  end

  hdx_led_stretch #(.LED_CYCLES(LED_CYCLES)) u_led (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trigger  (col_rise),
    .led_mode (led_mode),
    .led_n    (led_n)
  );

  assign col       = col_q;
  assign tp_out_en = tp_q;
  assign rxd_zero  = rz_q;

endmodule

// File: rtl/hdx_collision_chk.sv
module hdx_collision_chk
  import hdx_col_pkg::*;
(
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  tx_active,
  input logic                  rx_active,
  input logic                  full_duplex,
  input logic                  link_fail,
  input logic                  diag_loop,
  input logic                  col_test,
  input logic                  tx_en,
  input logic                  speed_10,
  input logic [LED_MODE_W-1:0] led_mode,
  input logic                  col,
  input logic                  crs,
  input logic                  tp_out_en,
  input logic                  rxd_zero,
  input logic                  crs_loop_en,
  input logic                  led_n
);

  logic open_g;
  assign open_g = !(full_duplex || link_fail || diag_loop);

  a_r1_overlap_col: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (open_g && tx_active && rx_active && !col_test) |=> col);

  a_r2_gate_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!open_g && !col_test) |=> !col);

  a_r3_crs_on_overlap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (open_g && tx_active && rx_active) |=> crs);

  a_r4_loop_off_in_col: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (open_g && tx_active && rx_active) |=> !crs_loop_en);

  a_r5_test_follows_txen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    col_test |=> (col == $past(tx_en)) && !tp_out_en);

  a_r7_no_zero_at_100: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !speed_10 |=> !rxd_zero);

  a_r9_led_idle_other_mode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (led_mode != LED_SEL_COLLISION) |=> led_n);

endmodule

bind hdx_collision_unit hdx_collision_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .tx_active   (tx_active),
  .rx_active   (rx_active),
  .full_duplex (full_duplex),
  .link_fail   (link_fail),
  .diag_loop   (diag_loop),
  .col_test    (col_test),
  .tx_en       (tx_en),
  .speed_10    (speed_10),
  .led_mode    (led_mode),
  .col         (col),
  .crs         (crs),
  .tp_out_en   (tp_out_en),
  .rxd_zero    (rxd_zero),
  .crs_loop_en (crs_loop_en),
  .led_n       (led_n)
);

// File: tb/tb_hdx_collision_unit.sv
module tb_hdx_collision_unit;

  localparam int CLK_PERIOD = 10;
  localparam int LED_CYC    = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_active, rx_active, full_duplex, link_fail, diag_loop;
  logic col_test, tx_en, speed_10, sqe_test, jabber;
  logic [1:0] led_mode;
  logic col, crs, tp_out_en, rxd_zero, crs_loop_en, led_n;

  int checks = 0;
  int fails  = 0;
  bit model_on = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdx_collision_unit #(.LED_CYCLES(LED_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
    .full_duplex(full_duplex), .link_fail(link_fail), .diag_loop(diag_loop),
    .col_test(col_test), .tx_en(tx_en), .speed_10(speed_10),
    .sqe_test(sqe_test), .jabber(jabber), .led_mode(led_mode),
    .col(col), .crs(crs), .tp_out_en(tp_out_en), .rxd_zero(rxd_zero),
    .crs_loop_en(crs_loop_en), .led_n(led_n)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  bit m_col, m_held, m_crs, m_loop, m_tp, m_rz, m_led;
  int m_cnt;

  always begin
    @(posedge clk);
    if (model_on) begin
      bit open, ovl, extra, ncol;
      open  = !(full_duplex || link_fail || diag_loop);
      ovl   = open && tx_active && rx_active;
      extra = open && speed_10 && (sqe_test || jabber);
      ncol  = col_test ? tx_en : (ovl || extra);
      if (ncol && !m_col) m_cnt = LED_CYC;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_led  = !(led_mode == 2'b10 && m_cnt != 0);
      m_col  = ncol;
      m_held = open && (ovl || (m_held && (tx_active || rx_active)));
      m_loop = !full_duplex && !m_held;
      m_crs  = rx_active || (tx_active && m_loop) || m_held;
      m_tp   = !col_test;
      m_rz   = speed_10 && (ovl || extra);
      #2;
      chk(col, m_col, "R1 R2 R5 R6 col");
      chk(crs, m_crs, "R3 crs");
      chk(crs_loop_en, m_loop, "R4 crs_loop_en");
      chk(tp_out_en, m_tp, "R5 tp_out_en");
      chk(rxd_zero, m_rz, "R7 rxd_zero");
      chk(led_n, m_led, "R8 R9 led_n");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {tx_active, rx_active, full_duplex, link_fail, diag_loop} = '0;
    {col_test, tx_en, speed_10, sqe_test, jabber} = '0;
    led_mode = 2'b10;
    step(3);
    // R10 reset state
    chk(col, 1'b0, "R10 col");
    chk(crs, 1'b0, "R10 crs");
    chk(rxd_zero, 1'b0, "R10 rxd_zero");
    chk(crs_loop_en, 1'b0, "R10 crs_loop_en");
    chk(tp_out_en, 1'b1, "R10 tp_out_en");
    chk(led_n, 1'b1, "R10 led_n");
    rst_n = 1'b1;
    step(4);
    m_col = 0; m_held = 0; m_cnt = 0;
    model_on = 1;

    // transmit only
    tx_active = 1; step(1);
    chk(crs, 1'b1, "R3 tx only crs");
    chk(crs_loop_en, 1'b1, "R4 tx only loop");
    chk(col, 1'b0, "R1 tx only col");
    // overlap
    rx_active = 1; step(1);
    chk(col, 1'b1, "R1 overlap col");
    chk(crs_loop_en, 1'b0, "R4 overlap loop");
    chk(led_n, 1'b0, "R8 overlap led");
    // receive drops first, collision held
    rx_active = 0; step(1);
    chk(col, 1'b0, "R1 end col");
    chk(crs, 1'b1, "R3 held crs");
    chk(crs_loop_en, 1'b0, "R4 held loop");
    tx_active = 0; step(1);
    chk(crs, 1'b0, "R3 release crs");
    chk(crs_loop_en, 1'b1, "R4 release loop");
    step(2);

    // gating, one at a time
    for (int g = 0; g < 3; g++) begin
      full_duplex = (g == 0); link_fail = (g == 1); diag_loop = (g == 2);
      tx_active = 1; rx_active = 1; step(1);
      chk(col, 1'b0, "R2 gated col");
      {full_duplex, link_fail, diag_loop} = '0;
      tx_active = 0; rx_active = 0; step(2);
    end

    // collision test
    col_test = 1; tx_en = 1; step(1);
    chk(col, 1'b1, "R5 test col high");
    chk(tp_out_en, 1'b0, "R5 test drivers off");
    tx_en = 0; step(1);
    chk(col, 1'b0, "R5 test col low");
    chk(rxd_zero, 1'b0, "R7 test no zero");
    col_test = 0; step(1);
    chk(tp_out_en, 1'b1, "R5 drivers back");
    step(2);

    // 10 Mbps extra sources
    speed_10 = 1; sqe_test = 1; step(1);
    chk(col, 1'b1, "R6 sqe col");
    chk(rxd_zero, 1'b1, "R7 sqe zero");
    sqe_test = 0; jabber = 1; step(1);
    chk(col, 1'b1, "R6 jabber col");
    jabber = 0; step(1);
    chk(col, 1'b0, "R6 quiet col");
    tx_active = 1; rx_active = 1; step(1);
    chk(rxd_zero, 1'b1, "R7 overlap zero");
    tx_active = 0; rx_active = 0; step(2);
    link_fail = 1; jabber = 1; step(1);
    chk(col, 1'b0, "R6 gated jabber");
    link_fail = 0; jabber = 0;
    speed_10 = 0; sqe_test = 1; step(1);
    chk(col, 1'b0, "R6 sqe at 100");
    chk(rxd_zero, 1'b0, "R7 sqe at 100");
    sqe_test = 0;

    // LED stretch and restart
    step(LED_CYC + 5);
    chk(led_n, 1'b1, "R8 led idle");
    tx_active = 1; rx_active = 1; step(1);
    tx_active = 0; rx_active = 0; step(5);
    tx_active = 1; rx_active = 1; step(1);
    tx_active = 0; rx_active = 0; step(LED_CYC - 2);
    chk(led_n, 1'b0, "R8 restarted led");
    step(2);
    chk(led_n, 1'b1, "R8 led expired");

    // other indicator mode
    led_mode = 2'b01;
    tx_active = 1; rx_active = 1; step(1);
    chk(led_n, 1'b1, "R9 other mode");
    tx_active = 0; rx_active = 0; step(3);

    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule